// File: doc/BRIEF.md
# Serial Byte Transmitter with Clear-to-Send Gating

This block turns a stream of bytes into asynchronous serial frames on a single output line. Bytes enter through a valid/ready port into a small first-in first-out buffer. A frame engine takes them out one at a time. Each frame carries a low start bit, the eight data bits least significant first, an optional parity bit, and a high stop bit. Every bit lasts a fixed number of baud ticks. Between frames the line rests high.

When flow control is enabled, an active-low clear-to-send input decides whether the next frame may begin. The input passes through a two-stage synchroniser and is consulted only when the engine is idle and about to start a frame. A frame that has begun is always sent to its stop bit. If clear-to-send is withdrawn, the line then rests high until the input is active again. The next byte then goes out starting with a fresh start bit. With flow control disabled, the clear-to-send input has no effect.

The back-pressure rules for the input port are these. A byte is taken on a rising clock edge when `in_valid` and `in_ready` are both 1. `in_ready` is 0 exactly when the buffer holds `FIFO_DEPTH` bytes. A byte offered while `in_ready` is 0 is not taken, and the sender must hold it until `in_ready` returns.

Top module: `uart_cts_tx`

## Requirements
- R1: Each frame is a start bit of 0, then data bits 0 to 7 in that order (LSB first), then a stop bit of 1. Each bit lasts exactly `TICKS_PER_BIT` (16) pulses of `baud_tick`, and the line is 1 whenever no frame is in progress.
- R2: With `parity_en`=1, a parity bit is inserted between data bit 7 and the stop bit. With `parity_odd`=0 it equals the XOR of the eight data bits (even parity). With `parity_odd`=1 it is that XOR inverted (odd parity). With `parity_en`=0 there is no parity bit.
- R3: A byte is accepted only on a clock edge with `in_valid`=1 and `in_ready`=1. `in_ready` is 0 while `FIFO_DEPTH` bytes are buffered. A byte offered while `in_ready`=0 is dropped and never transmitted. Accepted bytes are sent in arrival order.
- R4: With `flow_en`=0, `cts_n` has no effect, and buffered bytes are sent even while `cts_n`=1.
- R5: With `flow_en`=1 and `cts_n`=1 while idle, no start bit is sent and the line stays at 1.
- R6: With `flow_en`=1, raising `cts_n` during a frame does not shorten or corrupt that frame. The frame completes through its stop bit, and the line then stays at 1 while `cts_n` remains 1.
- R7: When `cts_n` returns to 0, the next buffered byte is sent as a complete frame beginning with its start bit.
- R8: `tx_idle` is 1 exactly when the buffer is empty and no frame is in progress. After reset, `tx`=1, `tx_idle`=1 and `in_ready`=1.
- R9: Bit timing counts `baud_tick` pulses, not clock cycles, so a tick every third clock stretches each bit to 3 x 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| in_valid | input | 1 | Byte offered on in_data |
| in_data | input | 8 | Byte to transmit |
| in_ready | output | 1 | Buffer can take a byte (0 = full) |
| parity_en | input | 1 | 1 inserts a parity bit |
| parity_odd | input | 1 | 0 even, 1 odd parity |
| flow_en | input | 1 | 1 enables clear-to-send gating |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| tx | output | 1 | Serial output line, idles at 1 |
| tx_idle | output | 1 | Buffer empty and no frame in progress |

## Verification
The bench builds the block with 8-bit data, a buffer depth of 4 and 16 ticks per bit. The shallow buffer lets the bench reach the full condition and test a dropped extra byte in a few pushes. All 256 byte values are swept without parity. A quarter of the byte space is swept in each parity sense. A tick every third clock tests that bit timing follows the tick and not the clock. Each frame is decoded from the line by sampling at mid-bit, and the bench compares it with the byte it pushed and with parity it computes itself.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  function automatic logic parity_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  output logic         push_ready,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign push_ready = (count != CW'(DEPTH));
  assign empty      = (count == '0);
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && !empty;
  assign pop_data   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: a full buffer does not grow when a byte is offered
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ready && !pop) |=> $stable(count));
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/cts_sync.sv
module cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n_async,
  output logic cts_n_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], cts_n_async};
  end

  assign cts_n_sync = chain[STAGES-1];
endmodule

// File: rtl/tx_frame_engine.sv
module tx_frame_engine
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              flow_en,
  input  logic              cts_n_sync,
  output logic              tx,
  output logic              busy
);
  localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_e         state;
  logic [TW-1:0]     tick_cnt;
  logic [IW-1:0]     bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              tx_q, par_q, pen_q;
  logic              bit_end, launch;

  assign launch   = (state == ST_IDLE) && !fifo_empty && (!flow_en || !cts_n_sync);
  assign fifo_pop = launch;
  assign bit_end  = baud_tick && (tick_cnt == TW'(TICKS_PER_BIT - 1));
  assign tx       = tx_q;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
    end else if (state == ST_IDLE) begin
      tick_cnt <= '0;
    end else if (baud_tick) begin
      tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tx_q    <= 1'b1;
      bit_idx <= '0;
      shreg   <= '0;
      par_q   <= 1'b0;
      pen_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          tx_q <= 1'b1;
          if (launch) begin
            shreg <= fifo_data;
            par_q <= parity_of(8'(fifo_data), parity_odd);
            pen_q <= parity_en;
            tx_q  <= 1'b0;
            state <= ST_START;
          end
        end
        ST_START: if (bit_end) begin
          state   <= ST_DATA;
          tx_q    <= shreg[0];
          bit_idx <= '0;
        end
        ST_DATA: if (bit_end) begin
          if (bit_idx == IW'(DATA_W - 1)) begin
            state <= pen_q ? ST_PARITY : ST_STOP;
            tx_q  <= pen_q ? par_q : 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            shreg   <= shreg >> 1;
            tx_q    <= shreg[1];
          end
        end
        ST_PARITY: if (bit_end) begin
          state <= ST_STOP;
          tx_q  <= 1'b1;
        end
        ST_STOP: if (bit_end) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: start bit low, stop bit and rest level high
  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START) |-> !tx);
  assert_stop_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP) |-> tx);
  assert_mark_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> tx);
  // R5: a frame is only launched while sending is permitted
  assert_launch_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (!flow_en || !cts_n_sync));
  // R6: a frame in flight never returns to idle before its stop bit
  assert_no_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START || state == ST_DATA || state == ST_PARITY) |=> (state != ST_IDLE));

endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx #(
  parameter int DATA_W        = 8,
  parameter int FIFO_DEPTH    = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              flow_en,
  input  logic              cts_n,
  output logic              tx,
  output logic              tx_idle
);
  logic              fifo_empty, fifo_pop, cts_n_s, busy;
  logic [DATA_W-1:0] fifo_data;

  tx_byte_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push_valid(in_valid), .push_data(in_data), .push_ready(in_ready),
    .pop(fifo_pop), .pop_data(fifo_data), .empty(fifo_empty)
  );

  cts_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .cts_n_async(cts_n), .cts_n_sync(cts_n_s)
  );

  tx_frame_engine #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) eng_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .parity_en(parity_en), .parity_odd(parity_odd),
    .flow_en(flow_en), .cts_n_sync(cts_n_s),
    .tx(tx), .busy(busy)
  );

  assign tx_idle = fifo_empty && !busy;

  // R8: the idle status never coexists with a driven-low line
  assert_idle_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> tx);

endmodule

// File: tb/uart_cts_tx_tb_top.sv
module uart_cts_tx_tb_top;
  localparam int DEPTH = 4;
  localparam int TPB   = 16;

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
  logic in_valid = 1'b0, parity_en = 1'b0, parity_odd = 1'b0, flow_en = 1'b0, cts_n = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, tx, tx_idle;

  int tests = 0, fails = 0, cyc = 0, tdiv = 1, tcnt = 0, zeros = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_cts_tx #(.DATA_W(8), .FIFO_DEPTH(DEPTH), .TICKS_PER_BIT(TPB)) dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .parity_en(parity_en), .parity_odd(parity_odd),
    .flow_en(flow_en), .cts_n(cts_n), .tx(tx), .tx_idle(tx_idle)
  );

  always @(negedge clk) begin
    if (tcnt >= tdiv - 1) begin tcnt <= 0; baud_tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; baud_tick <= 1'b0; end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!tx) zeros <= zeros + 1;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // decode one frame at mid-bit from the line
  task automatic rx_frame(input string tag, input logic [7:0] exp, input bit pen, input bit podd);
    int bp, w;
    logic [7:0] d;
    logic p, st, sp;
    bp = TPB * tdiv;
    w = 0;
    @(negedge clk);
    while (tx && w < 5000) begin @(negedge clk); w++; end
    chk(!tx, {tag, " start bit seen"}, tx, 0);
    repeat (bp / 2) @(negedge clk);
    st = tx;
    for (int i = 0; i < 8; i++) begin
      repeat (bp) @(negedge clk);
      d[i] = tx;
    end
    p = 1'b0;
    if (pen) begin
      repeat (bp) @(negedge clk);
      p = tx;
    end
    repeat (bp) @(negedge clk);
    sp = tx;
    chk(st == 1'b0 && sp == 1'b1 && d == exp, {tag, " frame"}, {st, d, sp}, {1'b0, exp, 1'b1});
    if (pen) chk(p == ((^exp) ^ podd), {tag, " parity R2"}, p, (^exp) ^ podd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx == 1'b1 && tx_idle == 1'b1 && in_ready == 1'b1, "R8 reset state",
        {tx, tx_idle, in_ready}, 3'b111);

    // R1: all byte values, no parity
    for (int b = 0; b < 256; b++) begin
      push(8'(b));
      if (b == 0) chk(tx_idle == 1'b0, "R8 busy during frame", tx_idle, 0);
      rx_frame("R1", 8'(b), 1'b0, 1'b0);
    end
    repeat (20) @(negedge clk);
    chk(tx_idle == 1'b1, "R8 idle after frames", tx_idle, 1);

    // R2: parity both senses
    parity_en = 1'b1;
    for (int m = 0; m < 2; m++) begin
      parity_odd = m[0];
      for (int b = 0; b < 64; b++) begin
        push(8'(b * 4 + m * 3 + 1));
        rx_frame("R2", 8'(b * 4 + m * 3 + 1), 1'b1, m[0]);
      end
    end
    parity_en = 1'b0; parity_odd = 1'b0;

    // R9: tick every third clock
    tdiv = 3;
    for (int b = 0; b < 6; b++) begin
      push(8'(8'h81 + b * 37));
      rx_frame("R9", 8'(8'h81 + b * 37), 1'b0, 1'b0);
    end
    tdiv = 1;
    repeat (10) @(negedge clk);

    // R4: gating off, cts ignored
    flow_en = 1'b0; cts_n = 1'b1;
    push(8'h5A);
    rx_frame("R4", 8'h5A, 1'b0, 1'b0);

    // R3/R5: fill buffer while blocked
    flow_en = 1'b1; cts_n = 1'b1;
    repeat (5) @(negedge clk);
    zeros = 0;
    for (int k = 0; k < DEPTH; k++) push(8'(8'h30 + k));
    @(negedge clk);
    chk(in_ready == 1'b0, "R3 full drops ready", in_ready, 0);
    in_valid = 1'b1; in_data = 8'hEE;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (300) @(negedge clk);
    chk(zeros == 0, "R5 line held at mark", zeros, 0);
    chk(tx_idle == 1'b0, "R8 not idle with data", tx_idle, 0);
    cts_n = 1'b0;
    for (int k = 0; k < DEPTH; k++) rx_frame("R3 order", 8'(8'h30 + k), 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    zeros = 0;
    repeat (400) @(negedge clk);
    chk(zeros == 0, "R3 dropped byte not sent", zeros, 0);
    chk(tx_idle == 1'b1, "R8 idle after drain", tx_idle, 1);

    // R6/R7: withdraw cts mid-frame
    push(8'hA5);
    push(8'h3C);
    fork
      begin
        wait (tx == 1'b0);
        repeat (40) @(negedge clk);
        cts_n = 1'b1;
      end
    join_none
    rx_frame("R6 in-flight", 8'hA5, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    zeros = 0;
    repeat (400) @(negedge clk);
    chk(zeros == 0, "R6 mark after frame", zeros, 0);
    chk(tx_idle == 1'b0, "R6 byte still pending", tx_idle, 0);
    cts_n = 1'b0;
    rx_frame("R7 resume", 8'h3C, 1'b0, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule